// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational block sits at the front of a double-precision fused multiply-add unit that computes z + x·y. It looks at the three 64-bit IEEE-754 operands together with two sign-negation controls and the active rounding mode. It then decides whether the operand mix already fixes the final answer. Examples are a NaN operand, an infinite term, or a product that is exactly zero.

When the answer is fixed, the block drives that answer and raises `special_valid`. It also raises `invalid_flag` where the operation is invalid. When the answer is not fixed, `special_valid` stays low and the arithmetic datapath must produce the result. Denormal normalization and the arithmetic itself are done elsewhere.

Each operand is placed in one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. The product sign is derived from the signs of x and y, and the z term is taken with its effective sign.

Top module: `fma_special_resolver`

## Requirements
- R1: The product sign is sign(x) XOR sign(y), inverted once more when `neg_prod` is 1. The effective sign of z is sign(z) inverted when `neg_addend` is 1.
- R2: Among NaN operands, any signalling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear) wins over every quiet NaN (fraction bit 51 set). Among NaNs of the same kind, z wins over x, and x wins over y.
- R3: A selected signalling NaN is returned with fraction bit 51 set, with its sign and other bits kept, and `invalid_flag` is 1. A selected quiet NaN is returned bit for bit with `invalid_flag` 0. A NaN result ignores both negate controls.
- R4: When one of x and y is infinite and the other is zero, in either order, the result is the default NaN 64'h7FF8000000000000 and `invalid_flag` is 1.
- R5: An infinite product combined with an infinite z of the opposite effective sign gives the default NaN with `invalid_flag` 1. In every other case, an infinite product gives infinity with the product sign.
- R6: A finite product, zero or nonzero, with an infinite z gives infinity with z's effective sign.
- R7: A zero product plus a zero z of opposite effective signs gives zero. That zero is negative only when `round_mode` is 2'b11 (round down); the other codes are 00 nearest, 01 toward zero and 10 up.
- R8: A zero product with either a zero z of the same effective sign or a nonzero finite z gives z with its effective sign bit and its other bits unchanged.
- R9: When the product is finite and nonzero and z is finite, `special_valid` and `invalid_flag` are 0 and `result` is all zeros.
- R10: `invalid_flag` is 1 only while `special_valid` is 1, and `special_valid` is 1 for every case in R3 to R8.
- R11: A denormal operand counts as a nonzero finite value. It never forces the result to zero and never makes a product special.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 64 | Addend operand |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Invert the product sign |
| neg_addend | input | 1 | Invert the addend sign |
| round_mode | input | 2 | 00 nearest, 01 toward zero, 10 up, 11 down |
| result | output | 64 | Resolved result; zero when not special |
| special_valid | output | 1 | The result is fixed by the operand classes |
| invalid_flag | output | 1 | Invalid-operation exception |

## Verification
The block has no state, so a wrong class decode or a wrong priority shows at the ports in the same cycle the operands are applied. The visible symptoms differ by fault:
- A swapped NaN priority returns the payload of the wrong operand.
- A lost quieting step leaves fraction bit 51 clear.
- A misread sign selects the wrong infinity or the wrong zero.

The vectors are chosen so that each such fault changes at least one of `result`, `special_valid` or `invalid_flag`. Examples are NaNs with distinct payloads in several operands at once, infinities in both orders, and zero sums under two rounding modes.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;

  // operand order for NaN priority: index 0 wins
  localparam int IDX_Z = 0;
  localparam int IDX_X = 1;
  localparam int IDX_Y = 2;
  localparam int N_OPS = 3;

  localparam logic [1:0] RM_DOWN = 2'b11;

  typedef struct packed {
    logic zero;
    logic sub;
    logic norm;
    logic inf;
    logic qnan;
    logic snan;
  } opclass_t;
endpackage

// File: rtl/fma_sp_classify.sv
module fma_sp_classify
  import fma_sp_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output opclass_t              cls
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones, exp_none, frac_none;

  assign exp_f     = op[WORD_W-2 -: EXP_W];
  assign frac_f    = op[FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign exp_none  = ~|exp_f;
  assign frac_none = ~|frac_f;

  always_comb begin
    cls      = '0;
    cls.zero = exp_none & frac_none;
    cls.sub  = exp_none & ~frac_none;
    cls.norm = ~exp_none & ~exp_ones;
    cls.inf  = exp_ones & frac_none;
    cls.qnan = exp_ones & frac_f[FRAC_W-1];
    cls.snan = exp_ones & ~frac_none & ~frac_f[FRAC_W-1];
  end

  always_comb begin
    AST_ONE_CLASS: assert ($onehot({cls.zero, cls.sub, cls.norm, cls.inf, cls.qnan, cls.snan}))
      else $error("operand falls in zero or several classes"); // R11
  end
endmodule

// File: rtl/fma_sp_nan_select.sv
module fma_sp_nan_select
  import fma_sp_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  logic [N_OPS-1:0][EXP_W+FRAC_W:0] ops,
  input  opclass_t [N_OPS-1:0]             cls,
  output logic                             nan_hit,
  output logic                             nan_invalid,
  output logic [EXP_W+FRAC_W:0]            nan_result
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;

  logic [WORD_W-1:0] pick;
  logic              s_hit, q_hit;

  always_comb begin
    pick  = '0;
    s_hit = 1'b0;
    q_hit = 1'b0;
    for (int i = 0; i < N_OPS; i++) begin
      if (!s_hit && cls[i].snan) begin
        s_hit = 1'b1;
        pick  = ops[i];
      end
    end
    for (int i = 0; i < N_OPS; i++) begin
      if (!s_hit && !q_hit && cls[i].qnan) begin
        q_hit = 1'b1;
        pick  = ops[i];
      end
    end
  end

  always_comb begin
    nan_hit     = s_hit | q_hit;
    nan_invalid = s_hit;
    nan_result  = pick;
    if (s_hit) nan_result[FRAC_W-1] = 1'b1;
  end

  always_comb begin
    if (nan_hit) begin
      AST_NAN_IS_QUIET: assert ((&nan_result[WORD_W-2 -: EXP_W]) && nan_result[FRAC_W-1])
        else $error("NaN output not quiet"); // R3
    end
  end
endmodule

// File: rtl/fma_sp_resolve.sv
module fma_sp_resolve
  import fma_sp_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  opclass_t              cls_x,
  input  opclass_t              cls_y,
  input  opclass_t              cls_z,
  input  logic                  prod_sign,
  input  logic                  z_sign,
  input  logic [EXP_W+FRAC_W-1:0] z_mag,
  input  logic [1:0]            rmode,
  output logic                  hit,
  output logic                  invalid,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic [WORD_W-1:0] INF_MAG = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic prod_bad, prod_inf, prod_zero, z_zero, z_inf;

  assign prod_bad  = (cls_x.inf & cls_y.zero) | (cls_x.zero & cls_y.inf);
  assign prod_inf  = (cls_x.inf | cls_y.inf) & ~prod_bad;
  assign prod_zero = (cls_x.zero | cls_y.zero) & ~prod_bad;
  assign z_zero    = cls_z.zero;
  assign z_inf     = cls_z.inf;

  always_comb begin
    hit     = 1'b1;
    invalid = 1'b0;
    result  = '0;
    if (prod_bad) begin
      invalid = 1'b1;
      result  = DFLT_NAN;
    end else if (prod_inf) begin
      if (z_inf && (z_sign != prod_sign)) begin
        invalid = 1'b1;
        result  = DFLT_NAN;
      end else begin
        result  = INF_MAG | {prod_sign, {(WORD_W-1){1'b0}}};
      end
    end else if (z_inf) begin
      result = INF_MAG | {z_sign, {(WORD_W-1){1'b0}}};
    end else if (prod_zero) begin
      if (z_zero && (z_sign != prod_sign)) begin
        result = {(rmode == RM_DOWN), {(WORD_W-1){1'b0}}};
      end else begin
        result = {z_sign, z_mag};
      end
    end else begin
      hit = 1'b0;
    end
  end

  always_comb begin
    if (invalid) begin
      AST_INVALID_GIVES_DEFAULT: assert (result == DFLT_NAN)
        else $error("invalid case without default NaN"); // R4
    end
  end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_sp_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  logic [63:0] op_z,
  input  logic [63:0] op_x,
  input  logic [63:0] op_y,
  input  logic        neg_prod,
  input  logic        neg_addend,
  input  logic [1:0]  round_mode,
  output logic [63:0] result,
  output logic        special_valid,
  output logic        invalid_flag
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;

  logic [N_OPS-1:0][WORD_W-1:0] ops;
  opclass_t [N_OPS-1:0]         cls;
  logic                         prod_sign, z_sign_eff;
  logic                         nan_hit, nan_inv;
  logic [WORD_W-1:0]            nan_res;
  logic                         rs_hit, rs_inv;
  logic [WORD_W-1:0]            rs_res;

  assign ops[IDX_Z] = op_z[WORD_W-1:0];
  assign ops[IDX_X] = op_x[WORD_W-1:0];
  assign ops[IDX_Y] = op_y[WORD_W-1:0];

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
      fma_sp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op  (ops[g]),
        .cls (cls[g])
      );
    end
  endgenerate

  assign prod_sign  = ops[IDX_X][WORD_W-1] ^ ops[IDX_Y][WORD_W-1] ^ neg_prod;
  assign z_sign_eff = ops[IDX_Z][WORD_W-1] ^ neg_addend;

  fma_sp_nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .ops         (ops),
    .cls         (cls),
    .nan_hit     (nan_hit),
    .nan_invalid (nan_inv),
    .nan_result  (nan_res)
  );

  fma_sp_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_res (
    .cls_x     (cls[IDX_X]),
    .cls_y     (cls[IDX_Y]),
    .cls_z     (cls[IDX_Z]),
    .prod_sign (prod_sign),
    .z_sign    (z_sign_eff),
    .z_mag     (ops[IDX_Z][WORD_W-2:0]),
    .rmode     (round_mode),
    .hit       (rs_hit),
    .invalid   (rs_inv),
    .result    (rs_res)
  );

  always_comb begin
    result        = '0;
    special_valid = nan_hit | rs_hit;
    invalid_flag  = nan_hit ? nan_inv : rs_inv;
    result[WORD_W-1:0] = nan_hit ? nan_res : rs_res;
  end

  always_comb begin
    AST_INVALID_NEEDS_SPECIAL: assert (!invalid_flag || special_valid)
      else $error("invalid raised outside a special case"); // R10
    if (!special_valid) begin
      AST_PLAIN_RESULT_ZERO: assert (result == '0)
        else $error("non-special case drives a result"); // R9
    end
  end
endmodule

// File: tb/fma_special_resolver_test.sv
module fma_special_resolver_test;
  logic        clk, rst_n;
  logic [63:0] op_z, op_x, op_y;
  logic        neg_prod, neg_addend;
  logic [1:0]  round_mode;
  logic [63:0] result;
  logic        special_valid, invalid_flag;

  typedef struct {
    logic [63:0] res;
    logic        sp;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  logic done   = 1'b0;

  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] DNAN = 64'h7FF8000000000000;
  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] MTWO = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] DEN  = 64'h0000000000000001;

  fma_special_resolver uut (
    .op_z(op_z), .op_x(op_x), .op_y(op_y),
    .neg_prod(neg_prod), .neg_addend(neg_addend), .round_mode(round_mode),
    .result(result), .special_valid(special_valid), .invalid_flag(invalid_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic drive(input logic [63:0] z, x, y, input logic np, na,
                       input logic [1:0] rm, input logic [63:0] er,
                       input logic es, ei, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    op_z = z; op_x = x; op_y = y;
    neg_prod = np; neg_addend = na; round_mode = rm;
    e.res = er; e.sp = es; e.inv = ei; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res || special_valid !== e.sp || invalid_flag !== e.inv) begin
        errors++;
        $display("FAIL %s: got res=%h sp=%b inv=%b, expected res=%h sp=%b inv=%b",
                 e.tag, result, special_valid, invalid_flag, e.res, e.sp, e.inv);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_z = '0; op_x = '0; op_y = '0;
    neg_prod = 1'b0; neg_addend = 1'b0; round_mode = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle: +0 + (+0 * +0) -> +0, special
    drive(PZ, PZ, PZ, 0, 0, 2'b00, PZ, 1, 0, "R8 idle zeros");
    // R2 sNaN in y beats qNaN in z; R3 quieting
    drive(64'h7FF8000000000007, ONE, 64'h7FF0000000000005, 0, 0, 2'b00,
          64'h7FF8000000000005, 1, 1, "R2 snan beats qnan");
    drive(64'hFFF0000000000002, 64'h7FF0000000000003, ONE, 0, 0, 2'b00,
          64'hFFF8000000000002, 1, 1, "R2 snan z before x");
    drive(ONE, 64'h7FF800000000000A, 64'hFFF800000000000B, 1, 1, 2'b00,
          64'h7FF800000000000A, 1, 0, "R3 qnan x unchanged");
    drive(64'hFFF8000000000C00, ONE, TWO, 1, 1, 2'b11,
          64'hFFF8000000000C00, 1, 0, "R3 qnan z ignores negate");
    drive(ONE, ONE, 64'h7FF0000000000009, 0, 0, 2'b00,
          64'h7FF8000000000009, 1, 1, "R3 snan y quieted");
    // R4
    drive(ONE, PINF, PZ, 0, 0, 2'b00, DNAN, 1, 1, "R4 inf times zero");
    drive(ONE, NZ, NINF, 0, 0, 2'b00, DNAN, 1, 1, "R4 zero times inf");
    // R5
    drive(NINF, PINF, TWO, 0, 0, 2'b00, DNAN, 1, 1, "R5 opposite infinities");
    drive(NINF, PINF, TWO, 0, 1, 2'b00, PINF, 1, 0, "R5 negated addend agrees");
    drive(ONE, NINF, TWO, 0, 0, 2'b00, NINF, 1, 0, "R5 inf product sign");
    drive(ONE, PINF, TWO, 1, 0, 2'b00, NINF, 1, 0, "R1 negate product on inf");
    drive(PINF, PINF, PINF, 1, 0, 2'b00, DNAN, 1, 1, "R1 negated product opposes z");
    // R6
    drive(NINF, ONE, TWO, 0, 0, 2'b00, NINF, 1, 0, "R6 finite product inf z");
    drive(NINF, PZ, TWO, 0, 1, 2'b00, PINF, 1, 0, "R6 negated inf z");
    // R7
    drive(NZ, PZ, ONE, 0, 0, 2'b00, PZ, 1, 0, "R7 opposite zeros nearest");
    drive(NZ, PZ, ONE, 0, 0, 2'b11, NZ, 1, 0, "R7 opposite zeros round down");
    drive(PZ, PZ, ONE, 0, 1, 2'b10, PZ, 1, 0, "R7 negate addend up mode");
    // R8
    drive(NZ, NZ, ONE, 0, 0, 2'b11, NZ, 1, 0, "R8 equal negative zeros");
    drive(TWO, PZ, ONE, 0, 0, 2'b00, TWO, 1, 0, "R8 zero product returns z");
    drive(TWO, PZ, ONE, 0, 1, 2'b00, MTWO, 1, 0, "R8 effective z sign");
    drive(DEN, PZ, ONE, 0, 0, 2'b00, DEN, 1, 0, "R11 denormal z kept");
    // R9 / R11
    drive(ONE, ONE, TWO, 0, 0, 2'b00, PZ, 0, 0, "R9 ordinary operands");
    drive(ONE, DEN, TWO, 1, 1, 2'b11, PZ, 0, 0, "R11 denormal product not special");
    drive(PZ, DEN, DEN, 0, 0, 2'b00, PZ, 0, 0, "R11 denormal product zero z");
    drive(NINF, DEN, ONE, 0, 0, 2'b00, NINF, 1, 0, "R10 denormal product inf z");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule